// File: doc/BRIEF.md
# Segment Translation Unit

This unit turns a segmented logical address (a 16-bit selector plus an offset) into a linear address. It keeps three segment slots: code, stack and data. Each slot caches a selector together with the base and limit taken from that selector's descriptor. The access kind of a translate request picks the slot implicitly. The current privilege level is the two low bits of the code slot's selector.

When protection is enabled, a slot load checks the selector and then reads the 8-byte descriptor from a descriptor table in memory. It does this as two 32-bit reads on a simple request/response memory port. The table's base and byte limit sit in a table register, and only a table-load request can write that register. Loads that break the rules fault and leave the slot unchanged. With protection disabled, the unit falls back to the flat "selector times 16 plus offset" scheme.

A load request and a translate request can arrive together while the unit is idle. While a descriptor fetch is in flight, both request ports are held off.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector is split into index (bits 15:3), table-select flag (bit 2) and requested privilege (bits 1:0). In protected mode, a load whose table-select flag is 1 pulses `load_fault` one cycle after acceptance and issues no memory read.
- R2: A load that passes the selector checks issues two reads: the first at table base + index*8, the second at that address + 4. Word 0 is the segment base. In word 1, bits 31:12 are the limit and bits 1:0 are the descriptor privilege; bits 11:2 are not interpreted.
- R3: A protected-mode load faults without any memory read when index*8+7 is greater than the table byte limit.
- R4: After the second read returns, a load faults if the descriptor privilege is numerically below the larger of the current privilege and the requested privilege. Otherwise it pulses `load_done`. A faulted load leaves the slot's selector, base and limit unchanged.
- R5: In protected mode, a translate accepted at one clock edge yields `xl_done` one cycle later. That cycle carries `xl_linear` = offset + slot base, and `xl_fault` = 1 unless offset < slot limit.
- R6: The access kind selects the slot: 0 selects code, 1 selects stack, and 2 and 3 both select data.
- R7: `cur_priv` always equals bits 1:0 of the code slot's selector.
- R8: A table-load request with `cur_priv` not 0 pulses `tbl_fault` and leaves the table register unchanged. At privilege 0 it writes base and limit with no fault.
- R9: With `prot_en` low, a translate gives selector*16 + offset with `xl_fault` 0. A load completes with `load_done` one cycle after acceptance and performs no memory read.
- R10: From acceptance of a fetching load until its outcome pulse, `load_ready` and `xl_ready` are 0 and translate requests wait.
- R11: After reset, every slot holds selector 0, base 0 and limit 0xFFFFF, and the table register holds base 0 and limit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Protection enable; low selects flat selector*16 mode |
| tbl_load | input | 1 | Request to write the table register |
| tbl_base_in | input | LIN_W | New table base |
| tbl_limit_in | input | TLIM_W | New table byte limit |
| tbl_fault | output | 1 | Pulse: table load refused |
| load_valid | input | 1 | Segment slot load request |
| load_slot | input | 2 | Slot to load: 0 code, 1 stack, 2 data |
| load_sel | input | 16 | Selector to load |
| load_ready | output | 1 | Unit accepts a load this cycle |
| load_done | output | 1 | Pulse: load committed |
| load_fault | output | 1 | Pulse: load refused |
| xl_valid | input | 1 | Translate request |
| xl_kind | input | 2 | Access kind: 0 code, 1 stack, 2/3 data |
| xl_offset | input | LIN_W | Offset to translate |
| xl_ready | output | 1 | Unit accepts a translate this cycle |
| xl_done | output | 1 | Pulse: translate result valid |
| xl_linear | output | LIN_W | Linear address |
| xl_fault | output | 1 | Limit violation on this result |
| cur_priv | output | 2 | Current privilege level |
| mem_req | output | 1 | Pulse: descriptor word read request |
| mem_addr | output | LIN_W | Read address |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The checker watches several rules on every cycle. Loads resolve to at most one outcome pulse, and a refused load never moves the privilege level. The privilege level changes only together with a committed load. A translate result appears only after an accepted request, flat-mode results never fault, memory reads occur only while the unit is busy, and a refused table load always traces back to a request made at nonzero privilege. The bench scenarios cover what these rules cannot show: the arithmetic of linear addresses, the exact fetch addresses, the privilege comparison across every descriptor and requested-privilege pair, and the fact that a refused table load leaves the old base in place for later fetches.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int SEL_W    = 16;
   localparam int DESC_W   = 32;
   localparam int LIM_LSB  = 12;
   localparam int NUM_SLOT = 3;
   localparam int SLOT_CODE  = 0;
   localparam int SLOT_STACK = 1;
   localparam int SLOT_DATA  = 2;

   // access kind -> slot; kinds 2 and 3 both go to the data slot
   function automatic logic [1:0] kind_to_slot(input logic [1:0] kind);
      case (kind)
         2'd0:    return 2'(SLOT_CODE);
         2'd1:    return 2'(SLOT_STACK);
         default: return 2'(SLOT_DATA);
      endcase
   endfunction

   function automatic logic [1:0] priv_max(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/seg_slot_bank.sv
module seg_slot_bank
   import seg_xlate_pkg::*;
#(
   parameter int LIN_W   = 32,
   parameter int LIMIT_W = 20
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [1:0]                           wr_slot,
   input  logic [SEL_W-1:0]                     wr_sel,
   input  logic [LIN_W-1:0]                     wr_base,
   input  logic [LIMIT_W-1:0]                   wr_limit,
   output logic [NUM_SLOT-1:0][SEL_W-1:0]       sel_o,
   output logic [NUM_SLOT-1:0][LIN_W-1:0]       base_o,
   output logic [NUM_SLOT-1:0][LIMIT_W-1:0]     limit_o
);
   for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
      logic [SEL_W-1:0]   sel_r;
      logic [LIN_W-1:0]   base_r;
      logic [LIMIT_W-1:0] limit_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_r   <= '0;
            base_r  <= '0;
            limit_r <= '1;
         end else if (wr_en && (wr_slot == 2'(g))) begin
            sel_r   <= wr_sel;
            base_r  <= wr_base;
            limit_r <= wr_limit;
         end
      end

      assign sel_o[g]   = sel_r;
      assign base_o[g]  = base_r;
      assign limit_o[g] = limit_r;
   end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int LIN_W   = 32,
   parameter int LIMIT_W = 20,
   parameter int TLIM_W  = 16
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prot_en,
   input  logic                req_valid,
   input  logic [1:0]          req_slot,
   input  logic [SEL_W-1:0]    req_sel,
   input  logic [1:0]          cur_priv,
   input  logic [LIN_W-1:0]    tbl_base,
   input  logic [TLIM_W-1:0]   tbl_limit,
   output logic                idle,
   output logic                mem_req,
   output logic [LIN_W-1:0]    mem_addr,
   input  logic [DESC_W-1:0]   mem_rdata,
   input  logic                mem_rvalid,
   output logic                wr_en,
   output logic [1:0]          wr_slot,
   output logic [SEL_W-1:0]    wr_sel,
   output logic [LIN_W-1:0]    wr_base,
   output logic [LIMIT_W-1:0]  wr_limit,
   output logic                done,
   output logic                fault
);
   typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} fst_e;
   fst_e state;

   logic [SEL_W-1:0] sel_q;
   logic [1:0]       slot_q;
   logic [LIN_W-1:0] base_q;
   logic [SEL_W-1:0] span;
   logic             take, flat_ld, bad_sel, bad_priv;

   always_comb begin
      span     = {req_sel[SEL_W-1:3], 3'b111};
      take     = (state == ST_IDLE) && req_valid;
      flat_ld  = take && !prot_en;
      bad_sel  = req_sel[2] || (LIN_W'(span) > LIN_W'(tbl_limit));
      bad_priv = mem_rdata[1:0] < priv_max(cur_priv, sel_q[1:0]);
      wr_en    = flat_ld || ((state == ST_HI) && mem_rvalid && !bad_priv);
      wr_slot  = flat_ld ? req_slot : slot_q;
      wr_sel   = flat_ld ? req_sel  : sel_q;
      wr_base  = flat_ld ? LIN_W'({req_sel, 4'b0000}) : base_q;
      wr_limit = flat_ld ? '1 : mem_rdata[LIM_LSB +: LIMIT_W];
   end

   assign idle = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sel_q    <= '0;
         slot_q   <= '0;
         base_q   <= '0;
         mem_req  <= 1'b0;
         mem_addr <= '0;
         done     <= 1'b0;
         fault    <= 1'b0;
      end else begin
         mem_req <= 1'b0;
         done    <= 1'b0;
         fault   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (flat_ld) begin
                  done <= 1'b1;
               end else if (take && bad_sel) begin
                  fault <= 1'b1;
               end else if (take) begin
                  sel_q    <= req_sel;
                  slot_q   <= req_slot;
                  mem_req  <= 1'b1;
                  mem_addr <= tbl_base + LIN_W'({req_sel[SEL_W-1:3], 3'b000});
                  state    <= ST_LO;
               end
            end
            ST_LO: begin
               if (mem_rvalid) begin
                  base_q   <= LIN_W'(mem_rdata);
                  mem_req  <= 1'b1;
                  mem_addr <= mem_addr + LIN_W'(4);
                  state    <= ST_HI;
               end
            end
            ST_HI: begin
               if (mem_rvalid) begin
                  state <= ST_IDLE;
                  done  <= !bad_priv;
                  fault <= bad_priv;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
   import seg_xlate_pkg::*;
#(
   parameter int LIN_W   = 32,
   parameter int LIMIT_W = 20
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              prot_en,
   input  logic                              go,
   input  logic [1:0]                        kind,
   input  logic [LIN_W-1:0]                  offset,
   input  logic [NUM_SLOT-1:0][SEL_W-1:0]    sel_i,
   input  logic [NUM_SLOT-1:0][LIN_W-1:0]    base_i,
   input  logic [NUM_SLOT-1:0][LIMIT_W-1:0]  limit_i,
   output logic                              done,
   output logic [LIN_W-1:0]                  linear,
   output logic                              fault
);
   logic [1:0]       slot;
   logic [LIN_W-1:0] lin_n;
   logic             flt_n;

   always_comb begin
      slot = kind_to_slot(kind);
      if (prot_en) begin
         lin_n = offset + base_i[slot];
         flt_n = !(offset < LIN_W'(limit_i[slot]));
      end else begin
         lin_n = LIN_W'({sel_i[slot], 4'b0000}) + offset;
         flt_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         linear <= '0;
         fault  <= 1'b0;
      end else begin
         done  <= go;
         fault <= go && flt_n;
         if (go) linear <= lin_n;
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int LIN_W   = 32,
   parameter int LIMIT_W = 20,
   parameter int TLIM_W  = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prot_en,
   input  logic               tbl_load,
   input  logic [LIN_W-1:0]   tbl_base_in,
   input  logic [TLIM_W-1:0]  tbl_limit_in,
   output logic               tbl_fault,
   input  logic               load_valid,
   input  logic [1:0]         load_slot,
   input  logic [15:0]        load_sel,
   output logic               load_ready,
   output logic               load_done,
   output logic               load_fault,
   input  logic               xl_valid,
   input  logic [1:0]         xl_kind,
   input  logic [LIN_W-1:0]   xl_offset,
   output logic               xl_ready,
   output logic               xl_done,
   output logic [LIN_W-1:0]   xl_linear,
   output logic               xl_fault,
   output logic [1:0]         cur_priv,
   output logic               mem_req,
   output logic [LIN_W-1:0]   mem_addr,
   input  logic [31:0]        mem_rdata,
   input  logic               mem_rvalid
);
   if (LIN_W < DESC_W) begin : g_bad_lin
      $error("seg_xlate_unit: LIN_W must be at least 32");
   end
   if (LIMIT_W < 1 || LIMIT_W > DESC_W - LIM_LSB) begin : g_bad_lim
      $error("seg_xlate_unit: LIMIT_W must be 1..20");
   end
   if (TLIM_W < 1 || TLIM_W > LIN_W) begin : g_bad_tlim
      $error("seg_xlate_unit: TLIM_W must be 1..LIN_W");
   end

   logic [LIN_W-1:0]  tbl_base_q;
   logic [TLIM_W-1:0] tbl_limit_q;
   logic              idle;
   logic              wr_en;
   logic [1:0]        wr_slot;
   logic [SEL_W-1:0]  wr_sel;
   logic [LIN_W-1:0]  wr_base;
   logic [LIMIT_W-1:0] wr_limit;
   logic [NUM_SLOT-1:0][SEL_W-1:0]   sel_arr;
   logic [NUM_SLOT-1:0][LIN_W-1:0]   base_arr;
   logic [NUM_SLOT-1:0][LIMIT_W-1:0] limit_arr;

   assign cur_priv   = sel_arr[SLOT_CODE][1:0];
   assign load_ready = idle;
   assign xl_ready   = idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_base_q  <= '0;
         tbl_limit_q <= '0;
         tbl_fault   <= 1'b0;
      end else begin
         tbl_fault <= tbl_load && (cur_priv != 2'd0);
         if (tbl_load && (cur_priv == 2'd0)) begin
            tbl_base_q  <= tbl_base_in;
            tbl_limit_q <= tbl_limit_in;
         end
      end
   end

   seg_desc_fetch #(.LIN_W(LIN_W), .LIMIT_W(LIMIT_W), .TLIM_W(TLIM_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
      .req_valid(load_valid), .req_slot(load_slot), .req_sel(load_sel),
      .cur_priv(cur_priv), .tbl_base(tbl_base_q), .tbl_limit(tbl_limit_q),
      .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_sel(wr_sel),
      .wr_base(wr_base), .wr_limit(wr_limit),
      .done(load_done), .fault(load_fault)
   );

   seg_slot_bank #(.LIN_W(LIN_W), .LIMIT_W(LIMIT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit),
      .sel_o(sel_arr), .base_o(base_arr), .limit_o(limit_arr)
   );

   seg_addr_calc #(.LIN_W(LIN_W), .LIMIT_W(LIMIT_W)) u_calc (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
      .go(xl_valid && idle), .kind(xl_kind), .offset(xl_offset),
      .sel_i(sel_arr), .base_i(base_arr), .limit_i(limit_arr),
      .done(xl_done), .linear(xl_linear), .fault(xl_fault)
   );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       prot_en,
   input logic       tbl_load,
   input logic       tbl_fault,
   input logic       load_ready,
   input logic       load_done,
   input logic       load_fault,
   input logic       xl_valid,
   input logic       xl_ready,
   input logic       xl_done,
   input logic       xl_fault,
   input logic [1:0] cur_priv,
   input logic       mem_req
);
   AST_XL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      xl_done |-> $past(xl_valid && xl_ready)); // R10
   AST_FLAT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_done && $past(!prot_en)) |-> !xl_fault); // R9
   AST_LOAD_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_done, load_fault})); // R4
   AST_FAULT_KEEPS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
      load_fault |-> $stable(cur_priv)); // R4
   AST_PRIV_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_priv) |-> load_done); // R7
   AST_TBL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_fault |-> ($past(tbl_load) && ($past(cur_priv) != 2'd0))); // R8
   AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !load_ready); // R2
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
   .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .tbl_load(tbl_load),
   .tbl_fault(tbl_fault), .load_ready(load_ready), .load_done(load_done),
   .load_fault(load_fault), .xl_valid(xl_valid), .xl_ready(xl_ready),
   .xl_done(xl_done), .xl_fault(xl_fault), .cur_priv(cur_priv), .mem_req(mem_req)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
   localparam logic [31:0] GBASE = 32'h0000_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_en = 1'b0;
   logic        tbl_load = 1'b0;
   logic [31:0] tbl_base_in = '0;
   logic [15:0] tbl_limit_in = '0;
   logic        tbl_fault;
   logic        load_valid = 1'b0;
   logic [1:0]  load_slot = '0;
   logic [15:0] load_sel = '0;
   logic        load_ready, load_done, load_fault;
   logic        xl_valid = 1'b0;
   logic [1:0]  xl_kind = '0;
   logic [31:0] xl_offset = '0;
   logic        xl_ready, xl_done, xl_fault;
   logic [31:0] xl_linear;
   logic [1:0]  cur_priv;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;

   int n_run = 0;
   int n_fail = 0;
   int req_cnt = 0;
   logic [31:0] first_a = '0;

   logic [15:0] m_sel  [3];
   logic [31:0] m_base [3];
   logic [19:0] m_lim  [3];

   always #4 clk = ~clk;

   seg_xlate_unit dut (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .tbl_load(tbl_load),
      .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in), .tbl_fault(tbl_fault),
      .load_valid(load_valid), .load_slot(load_slot), .load_sel(load_sel),
      .load_ready(load_ready), .load_done(load_done), .load_fault(load_fault),
      .xl_valid(xl_valid), .xl_kind(xl_kind), .xl_offset(xl_offset),
      .xl_ready(xl_ready), .xl_done(xl_done), .xl_linear(xl_linear), .xl_fault(xl_fault),
      .cur_priv(cur_priv), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   function automatic logic [31:0] d_base(input int i);
      return 32'h1000_0000 + 32'(i) * 32'h0001_1000;
   endfunction
   function automatic logic [19:0] d_lim(input int i);
      return 20'h00100 + 20'(i) * 20'h10;
   endfunction
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      int i;
      i = int'((a - GBASE) >> 3);
      if (a[2]) return {d_lim(i), 4'hA, 6'b0, 2'(i)};
      return d_base(i);
   endfunction
   function automatic int k2s(input int k);
      return (k == 0) ? 0 : (k == 1) ? 1 : 2;
   endfunction

   // memory: one-cycle response to each read request
   always @(posedge clk) begin
      mem_rvalid <= mem_req;
      mem_rdata  <= mem_word(mem_addr);
      if (mem_req) begin
         if (req_cnt == 0) first_a = mem_addr;
         req_cnt = req_cnt + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   logic r_done, r_flt;
   logic [31:0] r_lin;
   task automatic do_xl(input int kind, input logic [31:0] off);
      @(negedge clk);
      xl_valid = 1'b1; xl_kind = 2'(kind); xl_offset = off;
      @(negedge clk);
      xl_valid = 1'b0;
      r_done = xl_done; r_lin = xl_linear; r_flt = xl_fault;
   endtask

   logic l_ok, l_flt;
   task automatic do_load(input int slot, input logic [15:0] sel);
      req_cnt = 0;
      @(negedge clk);
      load_valid = 1'b1; load_slot = 2'(slot); load_sel = sel;
      @(negedge clk);
      load_valid = 1'b0;
      for (int k = 0; k < 20 && !(load_done || load_fault); k++) @(negedge clk);
      l_ok = load_done; l_flt = load_fault;
      @(negedge clk);
   endtask

   task automatic commit(input int slot, input logic [15:0] sel, input int i);
      m_sel[slot] = sel; m_base[slot] = d_base(i); m_lim[slot] = d_lim(i);
   endtask

   task automatic do_tbl(input logic [31:0] b, input logic [15:0] l);
      @(negedge clk);
      tbl_load = 1'b1; tbl_base_in = b; tbl_limit_in = l;
      @(negedge clk);
      tbl_load = 1'b0;
      r_flt = tbl_fault;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < 3; s++) begin
         m_sel[s] = '0; m_base[s] = '0; m_lim[s] = 20'hFFFFF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "cur_priv", 32'(cur_priv), 0);
      chk("R11", "load_ready", 32'(load_ready), 1);
      chk("R11", "xl_ready", 32'(xl_ready), 1);
      chk("R11", "mem_req", 32'(mem_req), 0);
      chk("R7", "priv after reset", 32'(cur_priv), 0);

      // R9 flat mode
      do_load(2, 16'h1234);
      chk("R9", "flat load done", 32'(l_ok), 1);
      chk("R9", "flat load reads", 32'(req_cnt), 0);
      m_sel[2] = 16'h1234;
      do_xl(2, 32'h10);
      chk("R9", "flat data linear", r_lin, 32'h0001_2350);
      chk("R5", "flat xl_done", 32'(r_done), 1);
      do_xl(0, 32'hFFFF_FFF0);
      chk("R9", "flat code linear", r_lin, 32'hFFFF_FFF0);
      chk("R9", "flat no fault", 32'(r_flt), 0);

      // R8 table load at privilege 0
      do_tbl(GBASE, 16'd127);
      chk("R8", "tbl load at priv0", 32'(r_flt), 0);
      prot_en = 1'b1;

      // R11 reset limits on stack and code slots
      do_xl(1, 32'h000F_FFFE);
      chk("R11", "reset limit edge ok", {r_lin[31:1], r_flt}, {32'h000F_FFFE >> 1, 1'b0});
      do_xl(0, 32'h000F_FFFF);
      chk("R11", "reset limit fault", 32'(r_flt), 1);

      // R2 R4 R5 sweep descriptors x requested privilege into data slot
      for (int i = 0; i < 16; i++) begin
         for (int rpl = 0; rpl < 4; rpl++) begin
            logic [15:0] sel;
            logic exp_ok;
            sel = {13'(i), 1'b0, 2'(rpl)};
            exp_ok = (i % 4) >= rpl;
            do_load(2, sel);
            chk("R4", $sformatf("outcome i=%0d rpl=%0d", i, rpl), {l_ok, l_flt}, {exp_ok, !exp_ok});
            chk("R2", "read count", 32'(req_cnt), 2);
            chk("R2", "first read address", first_a, GBASE + 32'(i) * 8);
            if (exp_ok) begin
               commit(2, sel, i);
               do_xl(2, 32'(m_lim[2]) - 1);
               chk("R5", "below limit linear", r_lin, m_base[2] + 32'(m_lim[2]) - 1);
               chk("R5", "below limit no fault", 32'(r_flt), 0);
               do_xl(3, 32'(m_lim[2]));
               chk("R5", "at limit fault", 32'(r_flt), 1);
            end else begin
               do_xl(2, 32'h4);
               chk("R4", "slot kept after fault", r_lin, m_base[2] + 32'h4);
            end
         end
      end

      // R1 table-select flag set
      do_load(2, {13'd1, 1'b1, 2'd0});
      chk("R1", "table flag fault", 32'(l_flt), 1);
      chk("R1", "table flag no read", 32'(req_cnt), 0);
      // R3 index beyond table limit
      do_load(2, {13'd16, 1'b0, 2'd0});
      chk("R3", "index over limit fault", 32'(l_flt), 1);
      chk("R3", "index over limit no read", 32'(req_cnt), 0);

      // R6 slot selection by kind
      do_load(0, {13'd4, 1'b0, 2'd0}); commit(0, {13'd4, 1'b0, 2'd0}, 4);
      do_load(1, {13'd5, 1'b0, 2'd0}); commit(1, {13'd5, 1'b0, 2'd0}, 5);
      do_load(2, {13'd6, 1'b0, 2'd0}); commit(2, {13'd6, 1'b0, 2'd0}, 6);
      for (int k = 0; k < 4; k++) begin
         do_xl(k, 32'h40);
         chk("R6", $sformatf("kind %0d base", k), r_lin, m_base[k2s(k)] + 32'h40);
      end

      // R10 stall during fetch
      @(negedge clk);
      load_valid = 1'b1; load_slot = 2'd1; load_sel = {13'd9, 1'b0, 2'd1};
      @(negedge clk);
      load_valid = 1'b0;
      chk("R10", "load_ready busy", 32'(load_ready), 0);
      chk("R10", "xl_ready busy", 32'(xl_ready), 0);
      xl_valid = 1'b1; xl_kind = 2'd1; xl_offset = 32'h8;
      for (int k = 0; k < 20 && !load_done; k++) begin
         chk("R10", "no result while busy", 32'(xl_done), 0);
         @(negedge clk);
      end
      chk("R10", "load committed", 32'(load_done), 1);
      @(negedge clk);
      xl_valid = 1'b0;
      commit(1, {13'd9, 1'b0, 2'd1}, 9);
      chk("R10", "stalled xl done", 32'(xl_done), 1);
      chk("R10", "stalled xl new base", xl_linear, d_base(9) + 32'h8);

      // R7 privilege follows code selector
      do_load(0, {13'd7, 1'b0, 2'd3});
      commit(0, {13'd7, 1'b0, 2'd3}, 7);
      chk("R7", "priv after code load", 32'(cur_priv), 3);

      // R8 refused table load keeps old base
      do_tbl(32'h0000_9000, 16'hFFFF);
      chk("R8", "tbl load refused", 32'(r_flt), 1);
      do_load(2, {13'd3, 1'b0, 2'd3});
      chk("R8", "old table base used", first_a, GBASE + 32'd24);
      chk("R4", "dpl3 at priv3 ok", 32'(l_ok), 1);
      commit(2, {13'd3, 1'b0, 2'd3}, 3);
      do_load(2, {13'd1, 1'b0, 2'd0});
      chk("R4", "dpl1 at priv3 fault", 32'(l_flt), 1);
      do_xl(2, 32'h20);
      chk("R4", "data slot unchanged", r_lin, d_base(3) + 32'h20);

      // R9 flat mode again uses selectors
      prot_en = 1'b0;
      do_xl(2, 32'hFFFF_0000);
      chk("R9", "flat uses selector", r_lin, {12'b0, m_sel[2], 4'b0} + 32'hFFFF_0000);
      chk("R9", "flat never faults", 32'(r_flt), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule